// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between free-running clock sources and a set of clock output lanes. It stops and restarts those lanes when an active-low stop request changes, and it does so without ever shortening a high or low phase. There are three lane groups. Fixed single-ended lanes always obey the stop request. Free-running single-ended lanes obey it only when their own mask bit is set. Differential lanes also obey it only when masked. A stopped differential lane either holds its true leg high with the complement floated, or floats both legs, as chosen by one shared drive-mode bit.

Each lane also has its own enable bit. The stop request crosses into each source domain through a two-flop synchroniser before it acts. Mask, enable and drive-mode inputs are quasi-static configuration and are sampled by each lane's gate register. Outputs are plain data, and each differential leg has a separate drive-enable, so the pad ring can build the tri-state.

Top module: `clkstop_gate`

## Requirements
- R1: `stop_n` is active low: 0 requests a stop and 1 requests a resume. While `rst` is high across source edges, every single-ended output is low, both drive-enables of every differential lane are 0, and the synchronisers hold the "run" value.
- R2: A fixed single-ended lane stops whenever a stop is requested. It has no mask.
- R3: A free-running single-ended lane stops only if its `fr_mask` bit is 1. With the bit at 0 it keeps toggling during a stop.
- R4: Timing of a single-ended lane. Let R1st and R2nd be the first and second rising edges of `clk_se` after `stop_n` changes. The lane's gate updates at the falling edge that follows R2nd. The change therefore appears from the third rising edge onward, and only whole high phases are produced.
- R5: A differential lane stops only if its `dif_mask` bit is 1. It enters the stopped state at the third rising edge of `clk_diff` after `stop_n` falls, and leaves it at the third rising edge after `stop_n` rises.
- R6: With `dif_float` = 0, a stopped differential lane drives its true leg high (`dif_t_oe`=1, `dif_t`=1) and floats its complement (`dif_c_oe`=0). With `dif_float` = 1, both drive-enables are 0.
- R7: An enable bit at 0 turns a lane off. For a differential lane, both drive-enables are 0 from the next rising edge of `clk_diff`. For a single-ended lane, the output is held low from the next falling edge of `clk_se`.
- R8: A running differential lane drives both legs (`dif_t_oe`=`dif_c_oe`=1). `dif_t` follows `clk_diff` and `dif_c` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_diff | input | 1 | Source clock for the differential lanes |
| clk_se | input | 1 | Source clock for the single-ended lanes |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| stop_n | input | 1 | Stop request, 0 = stop, 1 = run |
| fix_en | input | NFIX | Enables of the fixed single-ended lanes |
| fr_en | input | NFR | Enables of the free-running single-ended lanes |
| fr_mask | input | NFR | 1 = free-running lane obeys the stop request |
| dif_en | input | NDIF | Enables of the differential lanes |
| dif_mask | input | NDIF | 1 = differential lane obeys the stop request |
| dif_float | input | 1 | Stopped differential lanes: 0 = hold true leg high, 1 = float both legs |
| fix_out | output | NFIX | Gated fixed single-ended clocks |
| fr_out | output | NFR | Gated free-running single-ended clocks |
| dif_t | output | NDIF | True leg level of each differential lane |
| dif_c | output | NDIF | Complement leg level of each differential lane |
| dif_t_oe | output | NDIF | Drive-enable of each true leg |
| dif_c_oe | output | NDIF | Drive-enable of each complement leg |

## Verification
A change on `stop_n` reaches a differential lane's state at the third rising edge of `clk_diff`. It reaches a single-ended gate at the falling edge of `clk_se` that follows the second rising edge. An enable change takes one edge of the gate register's kind. The bench keeps its own per-domain model of those delays, stepped on the same source edges. It compares every output at sample points placed 1.25 ns after each `clk_diff` edge, which keeps them well clear of every `clk_se` edge. Each single-ended phase is sampled twice, so a runt or a missing pulse shows up as a miscompare.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/10ps
package clkstop_pkg;

    // Per-lane state of a differential output
    typedef enum logic [1:0] {
        LANE_OFF   = 2'd0,
        LANE_RUN   = 2'd1,
        LANE_HOLD  = 2'd2,
        LANE_FLOAT = 2'd3
    } lane_mode_e;

    // One differential leg: level plus drive-enable
    typedef struct packed {
        logic level;
        logic drive;
    } leg_t;

    function automatic lane_mode_e lane_next(input logic en,
                                             input logic halt,
                                             input logic float_sel);
        lane_mode_e m;
        if (!en)
            m = LANE_OFF;
        else if (halt)
            m = float_sel ? LANE_FLOAT : LANE_HOLD;
        else
            m = LANE_RUN;
        return m;
    endfunction

    function automatic leg_t true_leg(input lane_mode_e m, input logic src);
        leg_t l;
        case (m)
            LANE_RUN:  l = '{level: src,  drive: 1'b1};
            LANE_HOLD: l = '{level: 1'b1, drive: 1'b1};
            default:   l = '{level: 1'b0, drive: 1'b0};
        endcase
        return l;
    endfunction

    function automatic leg_t comp_leg(input lane_mode_e m, input logic src);
        leg_t l;
        if (m == LANE_RUN)
            l = '{level: ~src, drive: 1'b1};
        else
            l = '{level: 1'b0, drive: 1'b0};
        return l;
    endfunction

    function automatic logic se_run(input logic en,
                                    input logic halt,
                                    input logic stoppable);
        return en & ~(halt & stoppable);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/10ps
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else
            sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_se_lane.sv
`timescale 1ns/10ps
module clkstop_se_lane
    import clkstop_pkg::*;
(
    input  logic clk_src,
    input  logic rst,
    input  logic halt,
    input  logic en,
    input  logic stoppable,
    output logic clk_out
);
    logic run_q;

    // Gate changes only while the source is low
    always_ff @(negedge clk_src) begin
        if (rst)
            run_q <= 1'b0;
        else
            run_q <= se_run(en, halt, stoppable);
    end

    assign clk_out = clk_src & run_q;
endmodule

// File: rtl/clkstop_dif_lane.sv
`timescale 1ns/10ps
module clkstop_dif_lane
    import clkstop_pkg::*;
(
    input  logic clk_src,
    input  logic rst,
    input  logic halt,
    input  logic en,
    input  logic stoppable,
    input  logic float_sel,
    output logic t,
    output logic c,
    output logic t_oe,
    output logic c_oe
);
    lane_mode_e mode_q;
    leg_t       tl;
    leg_t       cl;

    // Mode changes at the rising edge, where the true leg is high
    always_ff @(posedge clk_src) begin
        if (rst)
            mode_q <= LANE_OFF;
        else
            mode_q <= lane_next(en, halt & stoppable, float_sel);
    end

    always_comb begin
        tl = true_leg(mode_q, clk_src);
        cl = comp_leg(mode_q, clk_src);
    end

    assign t    = tl.level;
    assign t_oe = tl.drive;
    assign c    = cl.level;
    assign c_oe = cl.drive;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/10ps
module clkstop_gate #(
    parameter int NFIX        = 4,
    parameter int NFR         = 3,
    parameter int NDIF        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_diff,
    input  logic            clk_se,
    input  logic            rst,
    input  logic            stop_n,
    input  logic [NFIX-1:0] fix_en,
    input  logic [NFR-1:0]  fr_en,
    input  logic [NFR-1:0]  fr_mask,
    input  logic [NDIF-1:0] dif_en,
    input  logic [NDIF-1:0] dif_mask,
    input  logic            dif_float,
    output logic [NFIX-1:0] fix_out,
    output logic [NFR-1:0]  fr_out,
    output logic [NDIF-1:0] dif_t,
    output logic [NDIF-1:0] dif_c,
    output logic [NDIF-1:0] dif_t_oe,
    output logic [NDIF-1:0] dif_c_oe
);
    logic run_se;
    logic run_dif;
    logic halt_se;
    logic halt_dif;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_se (
        .clk (clk_se),
        .rst (rst),
        .d   (stop_n),
        .q   (run_se)
    );

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_dif (
        .clk (clk_diff),
        .rst (rst),
        .d   (stop_n),
        .q   (run_dif)
    );

    assign halt_se  = ~run_se;
    assign halt_dif = ~run_dif;

    for (genvar i = 0; i < NFIX; i++) begin : g_fix
        clkstop_se_lane u_lane (
            .clk_src   (clk_se),
            .rst       (rst),
            .halt      (halt_se),
            .en        (fix_en[i]),
            .stoppable (1'b1),
            .clk_out   (fix_out[i])
        );
    end

    for (genvar i = 0; i < NFR; i++) begin : g_fr
        clkstop_se_lane u_lane (
            .clk_src   (clk_se),
            .rst       (rst),
            .halt      (halt_se),
            .en        (fr_en[i]),
            .stoppable (fr_mask[i]),
            .clk_out   (fr_out[i])
        );
    end

    for (genvar i = 0; i < NDIF; i++) begin : g_dif
        clkstop_dif_lane u_lane (
            .clk_src   (clk_diff),
            .rst       (rst),
            .halt      (halt_dif),
            .en        (dif_en[i]),
            .stoppable (dif_mask[i]),
            .float_sel (dif_float),
            .t         (dif_t[i]),
            .c         (dif_c[i]),
            .t_oe      (dif_t_oe[i]),
            .c_oe      (dif_c_oe[i])
        );
    end
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/10ps
module clkstop_gate_chk #(
    parameter int NFIX = 4,
    parameter int NFR  = 3,
    parameter int NDIF = 5
) (
    input logic            clk_diff,
    input logic            clk_se,
    input logic            rst,
    input logic [NFIX-1:0] fix_en,
    input logic [NFR-1:0]  fr_en,
    input logic [NDIF-1:0] dif_en,
    input logic            dif_float,
    input logic [NFIX-1:0] fix_out,
    input logic [NFR-1:0]  fr_out,
    input logic [NDIF-1:0] dif_t,
    input logic [NDIF-1:0] dif_c,
    input logic [NDIF-1:0] dif_t_oe,
    input logic [NDIF-1:0] dif_c_oe
);
    for (genvar i = 0; i < NDIF; i++) begin : g_dif_chk
        // R6: held stop state keeps the true leg high
        a_r6_hold_true_high: assert property (@(posedge clk_diff) disable iff (rst)
            (dif_t_oe[i] && !dif_c_oe[i]) |-> dif_t[i]);
        // R6: float mode never yields the held-high state
        a_r6_float_no_hold: assert property (@(posedge clk_diff) disable iff (rst)
            dif_float |=> !(dif_t_oe[i] && !dif_c_oe[i]));
        // R7: disabled lane floats both legs from the next edge
        a_r7_dif_off: assert property (@(posedge clk_diff) disable iff (rst)
            !dif_en[i] |=> (!dif_t_oe[i] && !dif_c_oe[i]));
        // R8: driven complement implies a driven, opposite true leg
        a_r8_legs_opposite: assert property (@(posedge clk_diff) disable iff (rst)
            dif_c_oe[i] |-> (dif_t_oe[i] && (dif_t[i] != dif_c[i])));
    end

    for (genvar i = 0; i < NFR; i++) begin : g_fr_chk
        // R7: disabled free-running lane gives no high phase
        a_r7_fr_off: assert property (@(negedge clk_se) disable iff (rst)
            !fr_en[i] |=> !fr_out[i]);
    end

    for (genvar i = 0; i < NFIX; i++) begin : g_fix_chk
        // R7: disabled fixed lane gives no high phase
        a_r7_fix_off: assert property (@(negedge clk_se) disable iff (rst)
            !fix_en[i] |=> !fix_out[i]);
    end
endmodule

bind clkstop_gate clkstop_gate_chk #(
    .NFIX (NFIX),
    .NFR  (NFR),
    .NDIF (NDIF)
) u_chk (
    .clk_diff  (clk_diff),
    .clk_se    (clk_se),
    .rst       (rst),
    .fix_en    (fix_en),
    .fr_en     (fr_en),
    .dif_en    (dif_en),
    .dif_float (dif_float),
    .fix_out   (fix_out),
    .fr_out    (fr_out),
    .dif_t     (dif_t),
    .dif_c     (dif_c),
    .dif_t_oe  (dif_t_oe),
    .dif_c_oe  (dif_c_oe)
);

// File: tb/clkstop_gate_bench.sv
`timescale 1ns/10ps
module clkstop_gate_bench;
    localparam int NFIX = 4;
    localparam int NFR  = 3;
    localparam int NDIF = 5;

    logic clk    = 1'b0;
    logic clk_se = 1'b0;
    logic rst    = 1'b1;
    logic stop_n = 1'b1;
    logic [NFIX-1:0] fix_en   = '1;
    logic [NFR-1:0]  fr_en    = '1;
    logic [NFR-1:0]  fr_mask  = '0;
    logic [NDIF-1:0] dif_en   = '1;
    logic [NDIF-1:0] dif_mask = '0;
    logic            dif_float = 1'b0;
    logic [NFIX-1:0] fix_out;
    logic [NFR-1:0]  fr_out;
    logic [NDIF-1:0] dif_t, dif_c, dif_t_oe, dif_c_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;              // 250 MHz differential source
    initial begin
        #0.5;
        forever #4 clk_se = ~clk_se;   // single-ended source, offset edges
    end

    clkstop_gate #(.NFIX(NFIX), .NFR(NFR), .NDIF(NDIF)) u_clkstop_gate (
        .clk_diff (clk),
        .clk_se   (clk_se),
        .rst      (rst),
        .stop_n   (stop_n),
        .fix_en   (fix_en),
        .fr_en    (fr_en),
        .fr_mask  (fr_mask),
        .dif_en   (dif_en),
        .dif_mask (dif_mask),
        .dif_float(dif_float),
        .fix_out  (fix_out),
        .fr_out   (fr_out),
        .dif_t    (dif_t),
        .dif_c    (dif_c),
        .dif_t_oe (dif_t_oe),
        .dif_c_oe (dif_c_oe)
    );

    // Expected-value model built from the latency rules (R4, R5, R7)
    // lane code: 0 off, 1 running, 2 stopped-driven, 3 stopped-floating
    logic md1, md2;
    logic [1:0] mst [NDIF];
    always @(posedge clk) begin
        if (rst) begin
            md1 <= 1'b1;
            md2 <= 1'b1;
            for (int i = 0; i < NDIF; i++) mst[i] <= 2'd0;
        end else begin
            md1 <= stop_n;
            md2 <= md1;
            for (int i = 0; i < NDIF; i++)
                mst[i] <= !dif_en[i] ? 2'd0 :
                          (!md2 && dif_mask[i]) ? (dif_float ? 2'd3 : 2'd2) : 2'd1;
        end
    end

    logic ms1, ms2;
    logic [NFIX-1:0] mrf;
    logic [NFR-1:0]  mrr;
    always @(posedge clk_se) begin
        if (rst) begin
            ms1 <= 1'b1;
            ms2 <= 1'b1;
        end else begin
            ms1 <= stop_n;
            ms2 <= ms1;
        end
    end
    always @(negedge clk_se) begin
        if (rst) begin
            mrf <= '0;
            mrr <= '0;
        end else begin
            mrf <= fix_en & {NFIX{ms2}};
            mrr <= fr_en & ~(fr_mask & {NFR{~ms2}});
        end
    end

    function automatic logic exp_t(input logic [1:0] s, input logic c);
        return (s == 2'd1) ? c : (s == 2'd2);
    endfunction
    function automatic logic exp_c(input logic [1:0] s, input logic c);
        return (s == 2'd1) ? ~c : 1'b0;
    endfunction
    function automatic logic exp_toe(input logic [1:0] s);
        return (s == 2'd1) || (s == 2'd2);
    endfunction
    function automatic logic exp_coe(input logic [1:0] s);
        return s == 2'd1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [NDIF-1:0] et, ec, eto, eco;
        for (int i = 0; i < NDIF; i++) begin
            et[i]  = exp_t(mst[i], clk);
            ec[i]  = exp_c(mst[i], clk);
            eto[i] = exp_toe(mst[i]);
            eco[i] = exp_coe(mst[i]);
        end
        if (rst) begin
            // R1: reset state
            chk("R1", "fix_out", 8'(fix_out), 8'(0));
            chk("R1", "fr_out", 8'(fr_out), 8'(0));
            chk("R1", "dif_t_oe", 8'(dif_t_oe), 8'(0));
            chk("R1", "dif_c_oe", 8'(dif_c_oe), 8'(0));
        end else begin
            chk("R1 R2 R4 R7", "fix_out", 8'(fix_out), 8'({NFIX{clk_se}} & mrf));
            chk("R3 R4 R7", "fr_out", 8'(fr_out), 8'({NFR{clk_se}} & mrr));
            chk("R5 R6 R8", "dif_t", 8'(dif_t), 8'(et));
            chk("R8", "dif_c", 8'(dif_c), 8'(ec));
            chk("R6 R7", "dif_t_oe", 8'(dif_t_oe), 8'(eto));
            chk("R5 R6 R8", "dif_c_oe", 8'(dif_c_oe), 8'(eco));
        end
    endtask

    task automatic run_steps(input int n);
        for (int k = 0; k < n; k++) begin
            check_all();
            #2;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1C));
        #1.25;
        #8;                          // let both domains see reset edges
        run_steps(6);                // R1 reset state
        rst = 1'b0;
        run_steps(40);               // R8 free running
        // R2, R3, R5: stop with every mask clear
        stop_n = 1'b0; run_steps(40);
        stop_n = 1'b1; run_steps(40);
        // R3, R5, R6: masks set, held-high mode
        fr_mask = '1; dif_mask = '1;
        stop_n = 1'b0; run_steps(40);
        stop_n = 1'b1; run_steps(40);
        // R6: floating mode
        dif_float = 1'b1;
        stop_n = 1'b0; run_steps(40);
        stop_n = 1'b1; run_steps(40);
        // R7: disables
        fix_en = 4'b0101; fr_en = 3'b010; dif_en = 5'b10101;
        run_steps(30);
        fix_en = '1; fr_en = '1; dif_en = '1;
        run_steps(30);
        // R4: short stop pulse narrower than a single-ended period
        stop_n = 1'b0; run_steps(1);
        stop_n = 1'b1; run_steps(30);
        // random phase
        for (int k = 0; k < 5000; k++) begin
            if ($urandom_range(15) == 0) stop_n = ~stop_n;
            if ($urandom_range(63) == 0) begin
                fix_en    = NFIX'($urandom | $urandom);
                fr_en     = NFR'($urandom | $urandom);
                fr_mask   = NFR'($urandom);
                dif_en    = NDIF'($urandom | $urandom);
                dif_mask  = NDIF'($urandom);
                dif_float = 1'($urandom);
            end
            run_steps(1);
        end
        finish_run();
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule